// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port memory and settles which port may use a location when both ports select the same address at once. Each port presents an active-low select, an active-low write request and an address. When both selects are active and the addresses are equal, the block grants the location to one port and drives an active-low busy flag to the other. It also gates each port's write strobe so that a port under busy cannot write. The busy flags are the same signals that neighbouring mailbox interrupt logic observes.

A mode input picks the role of the device. With the mode input high the device is the master: it runs its own arbitration and its busy outputs carry the result. With the mode input low the device is a slave: it skips its own arbitration and repeats the busy inputs taken from a master. Several devices placed side by side to widen the data word then agree on a single winner. Arbitration is synchronous to one clock: a port that already sat on the address in the previous cycle has priority, and a true tie either alternates between the ports or always goes to port A.

Top module: `dpc_arbiter`

## Requirements
- R1: In master mode, when either select is inactive or the two addresses differ, both busy outputs are high (inactive) in the same cycle.
- R2: In master mode at most one busy output is low at any time, and whenever both selects are active on equal addresses exactly one of them is low.
- R3: If one port was selected on an address in the previous cycle and is still selected on it, and the other port now arrives on that address (by asserting its select or by changing its address), the port already present is granted and the newcomer sees busy low.
- R4: A granted port keeps its grant for as long as both ports stay selected on the same unchanged address; the losing port's busy stays low for all of those cycles.
- R5: When both ports arrive on the same address in the same cycle, the grant follows a tie bit: with TIE_ALT=1 the first tie after reset goes to port A and each later tie goes to the other port than the previous tie; with TIE_ALT=0 every tie goes to port A.
- R6: In slave mode (mode input low) each busy output equals the matching busy input in the same cycle, whatever the selects and addresses are.
- R7: A port's write strobe is high exactly when its select is low, its write request is low, its own busy output is high and reset is complete, in both modes.
- R8: While the external reset is low and for two clock edges after it rises, both busy outputs are high and both write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| master_mode | input | 1 | 1: master, arbitrates and drives busy; 0: slave, repeats busy inputs |
| a_cs_n | input | 1 | Port A select, active low |
| a_we_n | input | 1 | Port A write request, active low |
| a_addr | input | ADDR_W | Port A address |
| b_cs_n | input | 1 | Port B select, active low |
| b_we_n | input | 1 | Port B write request, active low |
| b_addr | input | ADDR_W | Port B address |
| a_busy_in_n | input | 1 | Port A busy from the master (slave mode only), active low |
| b_busy_in_n | input | 1 | Port B busy from the master (slave mode only), active low |
| a_busy_n | output | 1 | Port A busy, active low |
| b_busy_n | output | 1 | Port B busy, active low |
| a_wr_stb | output | 1 | Port A write strobe passed to the array |
| b_wr_stb | output | 1 | Port B write strobe passed to the array |

## Verification
The hardest situation to reach is a true tie that follows a long history of non-tie collisions, since the alternating tie bit only moves on ties and is invisible at the ports until the next one. The stimulus first walks through hand-built first-arrival cases, then forces a run of ties by dropping both selects and re-entering on a common address in one cycle, and finally runs a long pseudo-random sweep over a two-bit address space, where collisions, re-arrivals and ties are dense, against a cycle model in the bench. Slave mode is swept over every combination of selects, write requests and busy inputs on a matching address.

// File: rtl/dpc_pkg.sv
`timescale 1ns/1ps
package dpc_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;

  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/dpc_rst_sync.sv
`timescale 1ns/1ps
module dpc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dpc_port_track.sv
`timescale 1ns/1ps
module dpc_port_track #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              on,
  output logic              stay
);
  logic              on_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  assign on = ~cs_n;

  // The port was already sitting on this very address last cycle.
  assign stay = on & on_q & (addr == addr_q);

  always_comb begin
    addr_en = on;
    addr_d  = addr_en ? addr : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      on_q   <= on;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/dpc_owner.sv
`timescale 1ns/1ps
module dpc_owner
  import dpc_pkg::*;
#(
  parameter bit TIE_ALT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master,
  input  logic       match,
  input  logic [1:0] stay,
  output owner_e     owner
);
  owner_e owner_q;
  owner_e owner_d;
  logic   tie_q;
  logic   tie_d;
  logic   tie_ev;
  logic   tie_en;

  always_comb begin
    tie_ev  = 1'b0;
    owner_d = OWN_NONE;
    if (match) begin
      if ((stay == 2'b11) && (owner_q != OWN_NONE)) begin
        owner_d = owner_q;
      end else if (stay == 2'b01) begin
        owner_d = OWN_A;
      end else if (stay == 2'b10) begin
        owner_d = OWN_B;
      end else begin
        tie_ev  = 1'b1;
        owner_d = (TIE_ALT && tie_q) ? OWN_B : OWN_A;
      end
    end
  end

  always_comb begin
    tie_en = tie_ev & master & TIE_ALT;
    tie_d  = tie_en ? ~tie_q : tie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      tie_q   <= 1'b0;
    end else begin
      owner_q <= owner_d;
      tie_q   <= tie_d;
    end
  end

  assign owner = owner_d;
endmodule

// File: rtl/dpc_out.sv
`timescale 1ns/1ps
module dpc_out
  import dpc_pkg::*;
(
  input  logic       rst_ok,
  input  logic       master,
  input  logic       match,
  input  owner_e     owner,
  input  logic [1:0] on,
  input  logic [1:0] we_n,
  input  logic [1:0] busy_in_n,
  output logic [1:0] busy_n,
  output logic [1:0] wr_stb
);
  logic [1:0] arb_busy_n;

  always_comb begin
    arb_busy_n[0] = ~(match & (owner == OWN_B));
    arb_busy_n[1] = ~(match & (owner == OWN_A));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      if (!rst_ok) begin
        busy_n[p] = 1'b1;
      end else if (master) begin
        busy_n[p] = arb_busy_n[p];
      end else begin
        busy_n[p] = busy_in_n[p];
      end
      wr_stb[p] = rst_ok & on[p] & ~we_n[p] & busy_n[p];
    end
  end
endmodule

// File: rtl/dpc_arbiter.sv
`timescale 1ns/1ps
module dpc_arbiter
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter bit          TIE_ALT    = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              a_cs_n,
  input  logic              a_we_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_cs_n,
  input  logic              b_we_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              a_busy_in_n,
  input  logic              b_busy_in_n,
  output logic              a_busy_n,
  output logic              b_busy_n,
  output logic              a_wr_stb,
  output logic              b_wr_stb
);
  logic              rst_ok;
  logic              match;
  logic [1:0]        cs_n_v;
  logic [1:0]        we_n_v;
  logic [1:0]        on_v;
  logic [1:0]        stay_v;
  logic [1:0]        busy_in_v;
  logic [1:0]        busy_v;
  logic [1:0]        wr_v;
  logic [ADDR_W-1:0] addr_v [NUM_PORTS];
  owner_e            owner;

  assign cs_n_v    = {b_cs_n, a_cs_n};
  assign we_n_v    = {b_we_n, a_we_n};
  assign busy_in_v = {b_busy_in_n, a_busy_in_n};
  assign addr_v[0] = a_addr;
  assign addr_v[1] = b_addr;

  dpc_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ok)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_track
    dpc_port_track #(.ADDR_W(ADDR_W)) track_i (
      .clk   (clk),
      .rst_n (rst_ok),
      .cs_n  (cs_n_v[p]),
      .addr  (addr_v[p]),
      .on    (on_v[p]),
      .stay  (stay_v[p])
    );
  end

  assign match = on_v[0] & on_v[1] & (addr_v[0] == addr_v[1]);

  dpc_owner #(.TIE_ALT(TIE_ALT)) owner_i (
    .clk    (clk),
    .rst_n  (rst_ok),
    .master (master_mode),
    .match  (match),
    .stay   (stay_v),
    .owner  (owner)
  );

  dpc_out out_i (
    .rst_ok    (rst_ok),
    .master    (master_mode),
    .match     (match),
    .owner     (owner),
    .on        (on_v),
    .we_n      (we_n_v),
    .busy_in_n (busy_in_v),
    .busy_n    (busy_v),
    .wr_stb    (wr_v)
  );

  assign a_busy_n = busy_v[0];
  assign b_busy_n = busy_v[1];
  assign a_wr_stb = wr_v[0];
  assign b_wr_stb = wr_v[1];
endmodule

// File: rtl/dpc_arbiter_chk.sv
`timescale 1ns/1ps
module dpc_arbiter_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_ok,
  input logic              master_mode,
  input logic              a_cs_n,
  input logic              a_we_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_cs_n,
  input logic              b_we_n,
  input logic [ADDR_W-1:0] b_addr,
  input logic              a_busy_in_n,
  input logic              b_busy_in_n,
  input logic              a_busy_n,
  input logic              b_busy_n,
  input logic              a_wr_stb,
  input logic              b_wr_stb
);
  logic coll;
  assign coll = !a_cs_n && !b_cs_n && (a_addr == b_addr);

  // R1
  idle_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (master_mode && !coll) |-> (a_busy_n && b_busy_n));

  // R2
  single_loser_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (master_mode && coll) |-> (a_busy_n != b_busy_n));

  // R4
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (master_mode && coll && $past(master_mode) && $past(!b_busy_n) &&
     $past(!a_cs_n) && !a_cs_n && (a_addr == $past(a_addr))) |-> !b_busy_n);

  // R4
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (master_mode && coll && $past(master_mode) && $past(!a_busy_n) &&
     $past(!b_cs_n) && !b_cs_n && (b_addr == $past(b_addr))) |-> !a_busy_n);

  // R6
  slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !master_mode |-> ((a_busy_n == a_busy_in_n) && (b_busy_n == b_busy_in_n)));

  // R7
  wr_gate_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr_stb |-> (!a_cs_n && !a_we_n && a_busy_n));

  // R7
  wr_gate_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr_stb |-> (!b_cs_n && !b_we_n && b_busy_n));

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |-> (a_busy_n && b_busy_n && !a_wr_stb && !b_wr_stb));
endmodule

bind dpc_arbiter dpc_arbiter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_ok      (rst_ok),
  .master_mode (master_mode),
  .a_cs_n      (a_cs_n),
  .a_we_n      (a_we_n),
  .a_addr      (a_addr),
  .b_cs_n      (b_cs_n),
  .b_we_n      (b_we_n),
  .b_addr      (b_addr),
  .a_busy_in_n (a_busy_in_n),
  .b_busy_in_n (b_busy_in_n),
  .a_busy_n    (a_busy_n),
  .b_busy_n    (b_busy_n),
  .a_wr_stb    (a_wr_stb),
  .b_wr_stb    (b_wr_stb)
);

// File: tb/dpc_arbiter_tb_top.sv
`timescale 1ns/1ps
module dpc_arbiter_tb_top;
  localparam int AW = 2;

  logic          clk;
  logic          rst_n;
  logic          master_mode;
  logic          a_cs_n, a_we_n, b_cs_n, b_we_n;
  logic [AW-1:0] a_addr, b_addr;
  logic          a_busy_in_n, b_busy_in_n;
  logic          a_busy_n, b_busy_n, a_wr_stb, b_wr_stb;

  int total = 0;
  int bad   = 0;

  dpc_arbiter #(.ADDR_W(AW), .TIE_ALT(1'b1)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .a_cs_n      (a_cs_n),
    .a_we_n      (a_we_n),
    .a_addr      (a_addr),
    .b_cs_n      (b_cs_n),
    .b_we_n      (b_we_n),
    .b_addr      (b_addr),
    .a_busy_in_n (a_busy_in_n),
    .b_busy_in_n (b_busy_in_n),
    .a_busy_n    (a_busy_n),
    .b_busy_n    (b_busy_n),
    .a_wr_stb    (a_wr_stb),
    .b_wr_stb    (b_wr_stb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Cycle model built from the requirements.
  logic [1:0]    m_rs;
  logic          m_en_a, m_en_b;
  logic [AW-1:0] m_ad_a, m_ad_b;
  int            m_own;  // 0 none, 1 A, 2 B
  logic          m_tie;

  function automatic logic m_match();
    return !a_cs_n && !b_cs_n && (a_addr == b_addr);
  endfunction

  function automatic logic m_sa();
    return m_en_a && !a_cs_n && (a_addr == m_ad_a);
  endfunction

  function automatic logic m_sb();
    return m_en_b && !b_cs_n && (b_addr == m_ad_b);
  endfunction

  function automatic logic m_is_tie();
    return m_match() && !(m_sa() && m_sb() && m_own != 0) && !(m_sa() ^ m_sb());
  endfunction

  function automatic int m_owner();
    if (!m_match()) return 0;
    if (m_sa() && m_sb() && m_own != 0) return m_own;
    if (m_sa() && !m_sb()) return 1;
    if (m_sb() && !m_sa()) return 2;
    return m_tie ? 2 : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= 2'b00; m_en_a <= 1'b0; m_en_b <= 1'b0;
      m_ad_a <= '0; m_ad_b <= '0; m_own <= 0; m_tie <= 1'b0;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (!m_rs[1]) begin
        m_en_a <= 1'b0; m_en_b <= 1'b0; m_ad_a <= '0; m_ad_b <= '0;
        m_own <= 0; m_tie <= 1'b0;
      end else begin
        m_en_a <= !a_cs_n; m_en_b <= !b_cs_n;
        if (!a_cs_n) m_ad_a <= a_addr;
        if (!b_cs_n) m_ad_b <= b_addr;
        m_own <= m_owner();
        if (m_is_tie() && master_mode) m_tie <= ~m_tie;
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic model_check(input string tag);
    logic ok, eab, ebb, eaw, ebw;
    int   o;
    ok = m_rs[1];
    o  = m_owner();
    if (!ok) begin
      eab = 1'b1; ebb = 1'b1;
    end else if (master_mode) begin
      eab = !(o == 2); ebb = !(o == 1);
    end else begin
      eab = a_busy_in_n; ebb = b_busy_in_n;
    end
    eaw = ok && !a_cs_n && !a_we_n && eab;
    ebw = ok && !b_cs_n && !b_we_n && ebb;
    check({tag, " a_busy_n"}, a_busy_n, eab);
    check({tag, " b_busy_n"}, b_busy_n, ebb);
    check("R7 a_wr_stb", a_wr_stb, eaw);
    check("R7 b_wr_stb", b_wr_stb, ebw);
  endtask

  task automatic step(input logic acs, input logic [AW-1:0] aad, input logic awe,
                      input logic bcs, input logic [AW-1:0] bad_, input logic bwe,
                      input string tag);
    @(negedge clk);
    a_cs_n = acs; a_addr = aad; a_we_n = awe;
    b_cs_n = bcs; b_addr = bad_; b_we_n = bwe;
    #5;
    model_check(tag);
  endtask

  task automatic do_reset(input logic mm);
    @(negedge clk);
    rst_n = 1'b0; master_mode = mm;
    a_cs_n = 1'b1; b_cs_n = 1'b1; a_we_n = 1'b1; b_we_n = 1'b1;
    a_addr = '0; b_addr = '0; a_busy_in_n = 1'b1; b_busy_in_n = 1'b1;
    repeat (2) @(negedge clk);
    #5;
    check("R8 reset a_busy_n", a_busy_n, 1'b1);
    check("R8 reset b_busy_n", b_busy_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    // Collide with writes during the synchronizer delay: outputs must stay quiet.
    step(1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0, "R8");
    check("R8 quiet a_wr_stb", a_wr_stb, 1'b0);
    check("R8 quiet b_busy_n", b_busy_n, 1'b1);
    step(1'b1, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, "R8");
    step(1'b1, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, "R8");
  endtask

  initial begin : watchdog
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    rst_n = 1'b0;
    master_mode = 1'b1;
    a_cs_n = 1'b1; b_cs_n = 1'b1; a_we_n = 1'b1; b_we_n = 1'b1;
    a_addr = '0; b_addr = '0; a_busy_in_n = 1'b1; b_busy_in_n = 1'b1;

    do_reset(1'b1);

    // R1: A alone
    step(1'b0, 2'd1, 1'b1, 1'b1, 2'd1, 1'b1, "R1");
    check("R1 alone b_busy_n", b_busy_n, 1'b1);
    // R3: B asserts select onto A's address
    step(1'b0, 2'd1, 1'b1, 1'b0, 2'd1, 1'b1, "R3");
    check("R3 ce-arrival b_busy_n", b_busy_n, 1'b0);
    check("R3 ce-arrival a_busy_n", a_busy_n, 1'b1);
    // R4 + R7: hold, both request writes
    step(1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0, "R4");
    check("R4 hold b_busy_n", b_busy_n, 1'b0);
    check("R7 winner a_wr_stb", a_wr_stb, 1'b1);
    check("R7 loser b_wr_stb", b_wr_stb, 1'b0);
    step(1'b0, 2'd1, 1'b1, 1'b0, 2'd1, 1'b1, "R4");
    check("R4 hold2 b_busy_n", b_busy_n, 1'b0);
    // R1: A leaves
    step(1'b1, 2'd1, 1'b1, 1'b0, 2'd1, 1'b1, "R1");
    check("R1 release b_busy_n", b_busy_n, 1'b1);
    // R3: A returns, B was present
    step(1'b0, 2'd1, 1'b1, 1'b0, 2'd1, 1'b1, "R3");
    check("R3 return a_busy_n", a_busy_n, 1'b0);
    // R1: address mismatch, then R3 via address change by B
    step(1'b0, 2'd1, 1'b1, 1'b0, 2'd2, 1'b1, "R1");
    check("R1 mismatch a_busy_n", a_busy_n, 1'b1);
    step(1'b0, 2'd1, 1'b1, 1'b0, 2'd1, 1'b1, "R3");
    check("R3 addr-move b_busy_n", b_busy_n, 1'b0);
    // R5: ties alternate A, B, A
    step(1'b1, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, "R1");
    step(1'b0, 2'd3, 1'b1, 1'b0, 2'd3, 1'b1, "R5");
    check("R5 tie1 b_busy_n", b_busy_n, 1'b0);
    step(1'b1, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, "R1");
    step(1'b0, 2'd3, 1'b1, 1'b0, 2'd3, 1'b1, "R5");
    check("R5 tie2 a_busy_n", a_busy_n, 1'b0);
    step(1'b0, 2'd2, 1'b1, 1'b0, 2'd1, 1'b1, "R1");
    step(1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, "R5");
    check("R5 tie3 b_busy_n", b_busy_n, 1'b0);

    // R2: long pseudo-random sweep in master mode
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[5], lfsr[2:1], lfsr[3], lfsr[6] & lfsr[11], lfsr[8:7], lfsr[9], "R2");
      if (!a_cs_n && !b_cs_n && a_addr == b_addr)
        check("R2 one loser", a_busy_n ^ b_busy_n, 1'b1);
    end

    // R6: slave mode, every select/write/busy-in combination on a shared address
    do_reset(1'b0);
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      a_busy_in_n = c[4];
      b_busy_in_n = c[5];
      step(c[0], 2'd2, c[1], c[2], 2'd2, c[3], "R6");
      check("R6 follow a", a_busy_n, c[4]);
      check("R6 follow b", b_busy_n, c[5]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule